// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division for a 32-bit load-store processor. Its results do not go to a general register. They land in a dedicated pair of result registers, HI and LO. A multiply spreads its double-width product across the pair. A divide puts the quotient in LO and the remainder in HI. The operands can be treated as two's-complement or as unsigned, and a single flag selects which. Two further operations copy an operand straight into HI or into LO. The processor reads HI and LO at any time through two output buses, and reading never changes them.

A one-cycle `start` pulse launches an operation. Multiply uses a shift-add datapath and divide uses a restoring datapath. Each works on operand magnitudes for W iterations, and a final correction cycle then restores the signs and writes the pair. A controller state machine sequences the work through three states. ST_IDLE waits for a request. ST_RUN performs one iteration per cycle. ST_FIX applies the sign correction and the write. The transitions are: IDLE to RUN on an accepted multiply or divide, RUN to RUN while iterations remain, RUN to FIX after the last iteration, and FIX to IDLE unconditionally. `busy` is high in RUN and FIX. A move-to request that arrives while the unit is busy is kept in a one-entry pending slot and applied on the completion edge.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op`=2'b00 (multiply) and `is_unsigned`=1, completion writes the low W bits of the unsigned 2W-bit product opa*opb to LO and the high W bits to HI.
- R2: With `op`=2'b00 and `is_unsigned`=0, the operands are two's complement and HI:LO receives the signed 2W-bit product.
- R3: With `op`=2'b01 (divide) and `is_unsigned`=1, completion writes the unsigned quotient opa/opb to LO and the remainder to HI.
- R4: A signed divide rounds the quotient toward zero and gives the remainder the sign of the dividend. The most negative value divided by -1 yields LO=the most negative value and HI=0.
- R5: A divide with opb=0 completes with normal timing, in either signedness, and writes all ones to LO and the unmodified dividend to HI.
- R6: `busy` rises on the edge that accepts a multiply or divide and stays high for exactly W+1 cycles. HI and LO keep their old values during the first W of those cycles and take the result on the edge where `busy` falls.
- R7: When idle, `op`=2'b10 with `start` copies opa into HI on that edge, and `op`=2'b11 with `start` copies opa into LO on that edge. The other register is left unchanged.
- R8: While idle with `start` low, HI and LO hold their values whatever the operand and op inputs do.
- R9: A multiply or divide `start` that arrives while busy is ignored. The running operation completes with its own result and its original timing.
- R10: A move-to request that arrives while busy does not change HI or LO before completion. It is applied on the completion edge and overrides the result in the register it targets. When several arrive, the latest one wins.
- R11: After reset, `busy`=0, HI=0 and LO=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 00 multiply, 01 divide, 10 move to HI, 11 move to LO |
| is_unsigned | input | 1 | 1 selects unsigned arithmetic, 0 selects two's complement |
| opa | input | W | Multiplicand, dividend, or move-to data |
| opb | input | W | Multiplier or divisor |
| busy | output | 1 | High while a multiply or divide is in progress |
| hi | output | W | HI register contents |
| lo | output | W | LO register contents |

## Verification
A move-to issued while idle is due one clock edge after the request. A multiply or divide result is due W+1 edges after its accepting edge, and `busy` falls on that same edge. The bench drives every request just after a falling edge and counts falling edges from that point. It checks `busy` high and HI/LO still unchanged at the edge just before the result is due, and checks the result exactly at the due edge. For interfering requests (a restart while busy, or a deferred move) the same count is kept, so each check shows that the interference neither shifted the completion edge nor leaked into HI/LO early.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_DIV  = 2'b01,
        OP_MTHI = 2'b10,
        OP_MTLO = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    output logic       busy,
    output logic       load,
    output logic       step,
    output logic       commit,
    output logic       mt_now,
    output logic       mt_defer
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    md_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          is_arith;

    assign is_arith = (md_op_e'(op) == OP_MUL) || (md_op_e'(op) == OP_DIV);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        busy     = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        commit   = 1'b0;
        mt_now   = 1'b0;
        mt_defer = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && is_arith) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
                mt_now = start && !is_arith;
            end
            ST_RUN: begin
                busy     = 1'b1;
                step     = 1'b1;
                mt_defer = start && !is_arith;
                if (cnt_q == LAST) state_d = ST_FIX;
            end
            ST_FIX: begin
                busy     = 1'b1;
                commit   = 1'b1;
                mt_defer = start && !is_arith;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [W:0]     sum;

    // add the multiplicand into the upper half when the current bit is set
    assign sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);

    always_ff @(posedge clk) begin
        if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {sum, prod_q[W-1:1]};
        end
    end

    assign prod = prod_q;

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvnd_in,
    input  logic [W-1:0] dvsr_in,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] dvsr_q, rem_q, quo_q;
    logic [W:0]   trial;

    // trial subtraction of the divisor from the shifted partial remainder
    assign trial = {rem_q, quo_q[W-1]} - {1'b0, dvsr_q};

    always_ff @(posedge clk) begin
        if (load) begin
            dvsr_q <= dvsr_in;
            rem_q  <= '0;
            quo_q  <= dvnd_in;
        end else if (step) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic         is_unsigned,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic           load, step, commit, mt_now, mt_defer;
    logic           a_neg, b_neg;
    logic [W-1:0]   a_mag, b_mag;
    logic [2*W-1:0] prod, prod_fix;
    logic [W-1:0]   quo, rem, quo_fix, rem_fix;
    logic [W-1:0]   res_hi, res_lo;

    logic           is_div_q, neg_a_q, neg_b_q, b_zero_q;
    logic [W-1:0]   a_orig_q;

    logic           pend_v_q, pend_hi_q;
    logic [W-1:0]   pend_d_q;
    logic           pv_eff, ph_eff;
    logic [W-1:0]   pd_eff;

    logic [W-1:0]   hi_q, lo_q;

    muldiv_ctrl #(.ITER(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .busy     (busy),
        .load     (load),
        .step     (step),
        .commit   (commit),
        .mt_now   (mt_now),
        .mt_defer (mt_defer)
    );

    // operand magnitudes
    assign a_neg = !is_unsigned && opa[W-1];
    assign b_neg = !is_unsigned && opb[W-1];
    assign a_mag = a_neg ? (~opa + 1'b1) : opa;
    assign b_mag = b_neg ? (~opb + 1'b1) : opb;

    muldiv_mul_core #(.W(W)) u_mul (
        .clk       (clk),
        .load      (load),
        .step      (step),
        .mcand_in  (b_mag),
        .mplier_in (a_mag),
        .prod      (prod)
    );

    muldiv_div_core #(.W(W)) u_div (
        .clk     (clk),
        .load    (load),
        .step    (step),
        .dvnd_in (a_mag),
        .dvsr_in (b_mag),
        .quo     (quo),
        .rem     (rem)
    );

    // operation context captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_div_q <= 1'b0;
            neg_a_q  <= 1'b0;
            neg_b_q  <= 1'b0;
            b_zero_q <= 1'b0;
            a_orig_q <= '0;
        end else if (load) begin
            is_div_q <= (md_op_e'(op) == OP_DIV);
            neg_a_q  <= a_neg;
            neg_b_q  <= b_neg;
            b_zero_q <= (opb == '0);
            a_orig_q <= opa;
        end
    end

    // sign correction
    assign prod_fix = (neg_a_q ^ neg_b_q) ? (~prod + 1'b1) : prod;
    assign quo_fix  = (neg_a_q ^ neg_b_q) ? (~quo + 1'b1) : quo;
    assign rem_fix  = neg_a_q ? (~rem + 1'b1) : rem;

    always_comb begin
        if (!is_div_q) begin
            res_hi = prod_fix[2*W-1:W];
            res_lo = prod_fix[W-1:0];
        end else if (b_zero_q) begin
            res_hi = a_orig_q;
            res_lo = '1;
        end else begin
            res_hi = rem_fix;
            res_lo = quo_fix;
        end
    end

    // deferred move-to slot, latest request wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v_q  <= 1'b0;
            pend_hi_q <= 1'b0;
            pend_d_q  <= '0;
        end else if (commit) begin
            pend_v_q  <= 1'b0;
        end else if (mt_defer) begin
            pend_v_q  <= 1'b1;
            pend_hi_q <= (md_op_e'(op) == OP_MTHI);
            pend_d_q  <= opa;
        end
    end

    assign pv_eff = mt_defer || pend_v_q;
    assign ph_eff = mt_defer ? (md_op_e'(op) == OP_MTHI) : pend_hi_q;
    assign pd_eff = mt_defer ? opa : pend_d_q;

    // HI/LO register pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (mt_now) begin
            if (md_op_e'(op) == OP_MTHI) hi_q <= opa;
            else                         lo_q <= opa;
        end else if (commit) begin
            hi_q <= (pv_eff && ph_eff)  ? pd_eff : res_hi;
            lo_q <= (pv_eff && !ph_eff) ? pd_eff : res_lo;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic         busy,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int BW = $clog2(W + 2) + 1;

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op[1]) |=> busy); // R6

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BW'(W + 1))); // R6

    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (bcnt < BW'(W))) |=> ((hi == $past(hi)) && (lo == $past(lo)))); // R10

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (bcnt < BW'(W))) |=> busy); // R9

    AST_MTHI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (op == 2'b10)) |=> ((hi == $past(opa)) && (lo == $past(lo)))); // R7

    AST_MTLO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (op == 2'b11)) |=> ((lo == $past(opa)) && (hi == $past(hi)))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ((hi == $past(hi)) && (lo == $past(lo)))); // R8

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (.*);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int LAT = W + 2;
    localparam int SEED = 32'h5eed_1234;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic         is_unsigned = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         busy;
    logic [W-1:0] hi, lo;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    muldiv_hilo #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .is_unsigned(is_unsigned), .opa(opa), .opb(opb),
        .busy(busy), .hi(hi), .lo(lo)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input bit uns, input logic [W-1:0] a, b);
        longint sa, sb;
        if (uns) return {32'b0, a} * {32'b0, b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return 64'(sa * sb);
    endfunction

    // returns {hi, lo}
    function automatic logic [2*W-1:0] ref_div(input bit uns, input logic [W-1:0] a, b);
        longint sa, sb, q, r;
        if (b == 0) return {a, 32'hffff_ffff};
        if (uns) return {a % b, a / b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic pulse(input logic [1:0] o, input bit uns, input logic [W-1:0] a, b);
        start = 1'b1; op = o; is_unsigned = uns; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; opa = $urandom; opb = $urandom;
    endtask

    task automatic do_arith(input string req, input logic [1:0] o, input bit uns,
                            input logic [W-1:0] a, b);
        logic [2*W-1:0] e;
        logic [W-1:0] old_hi, old_lo;
        e = (o == 2'b00) ? ref_mul(uns, a, b) : ref_div(uns, a, b);
        old_hi = hi; old_lo = lo;
        pulse(o, uns, a, b);
        chk("R6", "busy after start", {31'b0, busy}, 32'd1);
        repeat (LAT - 2) @(negedge clk);
        chk("R6", "busy before due", {31'b0, busy}, 32'd1);
        chk("R6", "hi frozen", hi, old_hi);
        @(negedge clk);
        chk("R6", "busy at due", {31'b0, busy}, 32'd0);
        chk(req, "hi", hi, e[2*W-1:W]);
        chk(req, "lo", lo, e[W-1:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hold_hi, hold_lo;
        int unsigned seed_v;
        seed_v = $urandom(SEED);
        repeat (3) @(negedge clk);
        chk("R11", "busy in reset", {31'b0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "hi after reset", hi, '0);
        chk("R11", "lo after reset", lo, '0);
        chk("R11", "busy after reset", {31'b0, busy}, 32'd0);

        // move-to while idle
        pulse(2'b10, 1'b0, 32'hdead_beef, 32'h0);
        chk("R7", "mthi hi", hi, 32'hdead_beef);
        chk("R7", "mthi lo", lo, 32'h0);
        pulse(2'b11, 1'b0, 32'h0bad_cafe, 32'h0);
        chk("R7", "mtlo lo", lo, 32'h0bad_cafe);
        chk("R7", "mtlo hi", hi, 32'hdead_beef);

        // idle hold with busy inputs but no start
        hold_hi = hi; hold_lo = lo;
        for (int i = 0; i < 6; i++) begin
            op = 2'(i); opa = $urandom; opb = $urandom; is_unsigned = i[0];
            @(negedge clk);
        end
        chk("R8", "hi held", hi, hold_hi);
        chk("R8", "lo held", lo, hold_lo);

        // directed corners
        do_arith("R1", 2'b00, 1'b1, 32'hffff_ffff, 32'hffff_ffff);
        do_arith("R1", 2'b00, 1'b1, 32'h1234_5678, 32'h9abc_def0);
        do_arith("R2", 2'b00, 1'b0, 32'hffff_ffff, 32'hffff_ffff);
        do_arith("R2", 2'b00, 1'b0, 32'hffff_fffd, 32'd5);
        do_arith("R2", 2'b00, 1'b0, 32'h8000_0000, 32'h8000_0000);
        do_arith("R3", 2'b01, 1'b1, 32'd100, 32'd7);
        do_arith("R3", 2'b01, 1'b1, 32'hffff_ffff, 32'd1);
        do_arith("R4", 2'b01, 1'b0, 32'hffff_fff9, 32'd2);
        do_arith("R4", 2'b01, 1'b0, 32'd7, 32'hffff_fffe);
        do_arith("R4", 2'b01, 1'b0, 32'h8000_0000, 32'hffff_ffff);
        do_arith("R5", 2'b01, 1'b1, 32'h1357_9bdf, 32'd0);
        do_arith("R5", 2'b01, 1'b0, 32'hffff_fff0, 32'd0);

        // restart attempt while busy is ignored
        begin
            logic [2*W-1:0] e;
            e = ref_mul(1'b1, 32'd1234, 32'd5678);
            pulse(2'b00, 1'b1, 32'd1234, 32'd5678);
            repeat (4) @(negedge clk);
            pulse(2'b01, 1'b0, 32'd99, 32'd3);
            repeat (LAT - 7) @(negedge clk);
            chk("R9", "busy before due", {31'b0, busy}, 32'd1);
            @(negedge clk);
            chk("R9", "busy at due", {31'b0, busy}, 32'd0);
            chk("R9", "hi keeps first op", hi, e[2*W-1:W]);
            chk("R9", "lo keeps first op", lo, e[W-1:0]);
        end

        // move-to while busy is deferred, latest wins
        begin
            logic [2*W-1:0] e;
            logic [W-1:0] old_lo;
            e = ref_div(1'b1, 32'd1000, 32'd7);
            old_lo = lo;
            pulse(2'b01, 1'b1, 32'd1000, 32'd7);
            repeat (9) @(negedge clk);
            pulse(2'b11, 1'b0, 32'h1111_1111, 32'h0);
            repeat (2) @(negedge clk);
            pulse(2'b11, 1'b0, 32'h2222_2222, 32'h0);
            repeat (LAT - 15) @(negedge clk);
            chk("R10", "lo not yet written", lo, old_lo);
            @(negedge clk);
            chk("R10", "lo takes latest move", lo, 32'h2222_2222);
            chk("R10", "hi keeps remainder", hi, e[2*W-1:W]);
        end

        // constrained random mix
        for (int i = 0; i < 48; i++) begin
            logic [31:0] r;
            logic [W-1:0] a, b;
            logic [1:0] o;
            bit uns;
            string req;
            r = $urandom;
            o = r[0] ? 2'b01 : 2'b00;
            uns = r[1];
            a = $urandom;
            b = $urandom;
            if (r[4:2] == 3'd0) b = '0;
            if (r[7:5] == 3'd0) b = b & 32'hff;
            if (r[10:8] == 3'd0) a = a & 32'hffff;
            if (o == 2'b00) req = uns ? "R1" : "R2";
            else if (b == 0) req = "R5";
            else req = uns ? "R3" : "R4";
            do_arith(req, o, uns, a, b);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule